// File: doc/BRIEF.md
# Segmented Bank-Mapping MMU

This block sits between a CPU with a 64 KB logical address space and a 1 MB physical memory bus. The logical space is cut into sixteen 4 KB segments. Each segment has a 4-bit register that names the 64 KB physical block the segment lands in. Software loads these registers with an I/O write to a fixed port. The upper bits of the I/O address pick the segment, and the register keeps the inverted low nibble of the data byte.

A separate control latch drives the enable input. While the enable is low, as it is after reset, every access goes to the top physical block (block F), so the CPU boots from ROM. Once the enable is set, each access is remapped through its segment register. The block decodes the physical address into RAM and ROM chip selects and gates the CPU read and write commands into memory strobes. The memory arrays lie outside the block.

Top module: `seg_bank_mmu`

## Requirements
- R1: After reset the mapping enable is clear and all sixteen segment registers hold 4'h0. Once the enable is set with no register written, every segment therefore maps to block 0.
- R2: A segment register is written when `io_wr` is high at a rising clock edge and `io_addr[7:1]` equals 7'h6F, which is port 8'hDE or 8'hDF because address bit 0 is ignored. The register written is the one indexed by `io_addr[15:12]`. It takes the value `io_data[3:0] ^ 4'hF`, and the new value is visible from the next cycle on.
- R3: An I/O write to any other port changes no segment register. `io_addr[11:8]` and `io_data[7:4]` have no effect on a register write.
- R4: While enabled, `phys_addr = {seg[cpu_addr[15:12]], cpu_addr[15:0]}`.
- R5: While disabled, `phys_addr = {4'hF, cpu_addr[15:0]}`. This holds for reads and writes alike.
- R6: The `map_en` input is registered. A change on it alters the translation from the cycle after the rising edge that samples it, and not before.
- R7: `ram_cs` is high exactly when `phys_addr[19:16]` is 4'h4, 4'h5, 4'hC or 4'hD.
- R8: `rom_cs` is high exactly when `phys_addr[19:16]` is 4'hF. The 8 KB ROM repeats through the whole block, so it is addressed by `phys_addr[12:0]`.
- R9: Any other physical block selects nothing. With no chip select, neither strobe rises, so writes are dropped and reads see the bus idle value.
- R10: `mem_rd_stb = cpu_rd & (ram_cs | rom_cs)` and `mem_wr_stb = cpu_wr & ram_cs`. A ROM access never raises the write strobe.
- R11: Translation, decode and strobes are combinational from `cpu_addr`, `cpu_rd`, `cpu_wr` and the registered state, so they follow address changes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| map_en | input | 1 | Mapping enable from the control latch, active high |
| io_wr | input | 1 | I/O write command |
| io_addr | input | 16 | I/O address; bits 7:1 select the port, bits 15:12 select the segment |
| io_data | input | 8 | I/O write data; the low nibble is used |
| cpu_addr | input | 16 | Logical memory address |
| cpu_rd | input | 1 | Memory read command |
| cpu_wr | input | 1 | Memory write command |
| phys_addr | output | 20 | Translated physical address |
| ram_cs | output | 1 | RAM region select |
| rom_cs | output | 1 | ROM region select |
| mem_rd_stb | output | 1 | Gated memory read strobe |
| mem_wr_stb | output | 1 | Gated memory write strobe |

## Verification
The bench loads every nibble value into every segment and probes several offsets in each segment. It also probes every segment while disabled. A design that stored the nibble without inverting it, or indexed registers with the wrong address bits, would send traffic to the wrong block. The bench writes port 8'hDF and ports next to 8'hDE, with junk in the ignored bits. A decoder that looked at bit 0 or at the wrong bits would then miss a legal write or take a stray one. The bench also checks the cycle in which an enable change lands, and it issues writes into ROM and unmapped blocks. A design with an unregistered enable, or with a write strobe not gated by the RAM select, would show up there.

// File: rtl/segmap_pkg.sv
package segmap_pkg;
    localparam int unsigned LOG_W   = 16;
    localparam int unsigned OFF_W   = 12;
    localparam int unsigned SEG_W   = LOG_W - OFF_W;
    localparam int unsigned NSEG    = 1 << SEG_W;
    localparam int unsigned BLK_W   = 4;
    localparam int unsigned PHYS_W  = BLK_W + LOG_W;
    localparam int unsigned N_RAMBLK = 4;

    typedef logic [BLK_W-1:0] blk_t;
    typedef blk_t [NSEG-1:0]  seg_arr_t;

    typedef struct packed {
        seg_arr_t seg;
        logic     en;
    } ctl_state_t;

    localparam blk_t BOOT_BLK = '1;
    localparam blk_t ROM_BLK  = '1;
    localparam blk_t [N_RAMBLK-1:0] RAM_BLK_LIST = {4'hD, 4'hC, 4'h5, 4'h4};
endpackage

// File: rtl/mmu_port_decode.sv
module mmu_port_decode
    import segmap_pkg::*;
#(
    parameter logic [7:0] IO_PORT = 8'hDE
) (
    input  logic             io_wr,
    input  logic [LOG_W-1:0] io_addr,
    input  logic [7:0]       io_data,
    output logic             hit,
    output logic [SEG_W-1:0] seg_idx,
    output blk_t             seg_val
);
    logic unused_bits;

    always_comb begin
        hit     = io_wr && (io_addr[7:1] == IO_PORT[7:1]);
        seg_idx = io_addr[LOG_W-1:OFF_W];
        seg_val = io_data[BLK_W-1:0] ^ {BLK_W{1'b1}};
    end

    assign unused_bits = &{1'b0, io_addr[OFF_W-1:8], io_addr[0], io_data[7:BLK_W]};
endmodule

// File: rtl/mmu_ctl_regs.sv
module mmu_ctl_regs
    import segmap_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             map_en,
    input  logic             wr_hit,
    input  logic [SEG_W-1:0] wr_idx,
    input  blk_t             wr_val,
    output seg_arr_t         seg,
    output logic             en
);
    ctl_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.en = map_en;
        if (wr_hit) begin
            st_d.seg[wr_idx] = wr_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign seg = st_q.seg;
    assign en  = st_q.en;

    // R2: a decoded write lands in the indexed register next cycle
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> seg[$past(wr_idx)] == $past(wr_val));

    // R3: without a decoded write the register file holds
    a_r3_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(seg));

    // R6: enable follows the input one cycle later
    a_r6_en_registered: assert property (@(posedge clk) disable iff (!rst_n)
        map_en |=> en);
endmodule

// File: rtl/mmu_xlate.sv
module mmu_xlate
    import segmap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  seg_arr_t          seg,
    input  logic              en,
    input  logic [LOG_W-1:0]  cpu_addr,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    output logic [PHYS_W-1:0] phys_addr,
    output logic              ram_cs,
    output logic              rom_cs,
    output logic              mem_rd_stb,
    output logic              mem_wr_stb
);
    blk_t                blk;
    logic [N_RAMBLK-1:0] ram_match;

    always_comb begin
        blk       = en ? seg[cpu_addr[LOG_W-1:OFF_W]] : BOOT_BLK;
        phys_addr = {blk, cpu_addr};
    end

    for (genvar g = 0; g < N_RAMBLK; g++) begin : g_ram
        assign ram_match[g] = (blk == RAM_BLK_LIST[g]);
    end

    always_comb begin
        ram_cs     = |ram_match;
        rom_cs     = (blk == ROM_BLK);
        mem_rd_stb = cpu_rd && (ram_cs || rom_cs);
        mem_wr_stb = cpu_wr && ram_cs;
    end

    // R7/R8: at most one region selected
    a_r7_cs_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ram_cs, rom_cs}));

    // R10: ROM never sees a write strobe
    a_r10_rom_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        rom_cs |-> !mem_wr_stb);

    // R5: disabled mode always lands in the ROM block
    a_r5_boot_in_rom: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (rom_cs && phys_addr[PHYS_W-1:LOG_W] == 4'hF));

    // R9: unmapped space gets no strobe
    a_r9_unmapped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_cs || rom_cs) |-> !(mem_rd_stb || mem_wr_stb));
endmodule

// File: rtl/seg_bank_mmu.sv
module seg_bank_mmu
    import segmap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              map_en,
    input  logic              io_wr,
    input  logic [15:0]       io_addr,
    input  logic [7:0]        io_data,
    input  logic [15:0]       cpu_addr,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    output logic [19:0]       phys_addr,
    output logic              ram_cs,
    output logic              rom_cs,
    output logic              mem_rd_stb,
    output logic              mem_wr_stb
);
    logic             wr_hit;
    logic [SEG_W-1:0] wr_idx;
    blk_t             wr_val;
    seg_arr_t         seg;
    logic             en;

    mmu_port_decode #(.IO_PORT(8'hDE)) u_dec (
        .io_wr   (io_wr),
        .io_addr (io_addr),
        .io_data (io_data),
        .hit     (wr_hit),
        .seg_idx (wr_idx),
        .seg_val (wr_val)
    );

    mmu_ctl_regs u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .map_en (map_en),
        .wr_hit (wr_hit),
        .wr_idx (wr_idx),
        .wr_val (wr_val),
        .seg    (seg),
        .en     (en)
    );

    mmu_xlate u_xl (
        .clk        (clk),
        .rst_n      (rst_n),
        .seg        (seg),
        .en         (en),
        .cpu_addr   (cpu_addr),
        .cpu_rd     (cpu_rd),
        .cpu_wr     (cpu_wr),
        .phys_addr  (phys_addr),
        .ram_cs     (ram_cs),
        .rom_cs     (rom_cs),
        .mem_rd_stb (mem_rd_stb),
        .mem_wr_stb (mem_wr_stb)
    );

    // R11: the low 16 physical bits pass straight through
    a_r11_offset_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        phys_addr[15:0] == cpu_addr);
endmodule

// File: tb/seg_bank_mmu_bench.sv
module seg_bank_mmu_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic map_en = 1'b0, io_wr = 1'b0, cpu_rd = 1'b0, cpu_wr = 1'b0;
    logic [15:0] io_addr = '0, cpu_addr = '0;
    logic [7:0] io_data = '0;
    logic [19:0] phys_addr;
    logic ram_cs, rom_cs, mem_rd_stb, mem_wr_stb;

    int n_chk = 0, n_bad = 0;
    logic [3:0] seg_m [16];
    logic en_m = 1'b0;

    always #2 clk = ~clk;

    seg_bank_mmu u_seg_bank_mmu (
        .clk(clk), .rst_n(rst_n), .map_en(map_en), .io_wr(io_wr),
        .io_addr(io_addr), .io_data(io_data), .cpu_addr(cpu_addr),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .phys_addr(phys_addr),
        .ram_cs(ram_cs), .rom_cs(rom_cs), .mem_rd_stb(mem_rd_stb),
        .mem_wr_stb(mem_wr_stb)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // drive a memory access and compare against the model (R4,R5,R7,R8,R9,R10,R11)
    task automatic probe(input string req, input logic [15:0] a, input logic rd, input logic wr);
        logic [3:0] b;
        logic ram, rom;
        @(negedge clk);
        cpu_addr = a; cpu_rd = rd; cpu_wr = wr;
        #1;
        b   = en_m ? seg_m[a[15:12]] : 4'hF;
        ram = (b == 4'h4) || (b == 4'h5) || (b == 4'hC) || (b == 4'hD);
        rom = (b == 4'hF);
        check(req, {12'h0, phys_addr}, {12'h0, b, a});
        check(req, {28'h0, ram_cs, rom_cs, mem_rd_stb, mem_wr_stb},
              {28'h0, ram, rom, rd & (ram | rom), wr & ram});
    endtask

    task automatic io_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_wr = 1'b1; io_addr = a; io_data = d;
        @(negedge clk);
        io_wr = 1'b0;
        if (a[7:1] == 7'h6F) seg_m[a[15:12]] = d[3:0] ^ 4'hF;
    endtask

    task automatic set_en(input logic v);
        @(negedge clk);
        map_en = v;
        @(negedge clk);
        en_m = v;
    endtask

    initial begin
        for (int i = 0; i < 16; i++) seg_m[i] = 4'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 + R5: reset state is disabled, everything lands in block F
        for (int s = 0; s < 16; s++) begin
            probe("R5", 16'(s << 12) | 16'h0123, 1'b1, 1'b0);
            probe("R5", 16'(s << 12) | 16'h0FFE, 1'b0, 1'b1);
        end

        // R6: change takes effect only after the sampling edge
        @(negedge clk);
        map_en = 1'b1;
        #1;
        check("R6", {12'h0, phys_addr}, {12'h0, 4'hF, cpu_addr});
        @(negedge clk);
        en_m = 1'b1;
        // R1: registers reset to 0 -> block 0, unmapped (R9)
        probe("R1", 16'h7ABC, 1'b1, 1'b1);
        probe("R9", 16'h0000, 1'b1, 1'b1);

        // R2/R4/R7/R8/R10: every value in every segment
        for (int s = 0; s < 16; s++) begin
            for (int v = 0; v < 16; v++) begin
                io_write(16'(s << 12) | 16'h0ADE | (v[0] ? 16'h0001 : 16'h0000),
                         8'(v) | 8'hA0);
                probe("R2", 16'(s << 12) | 16'(v * 16'h00F1), 1'b1, 1'b0);
                probe("R4", 16'(s << 12) | 16'h0FFF, 1'b0, 1'b1);
            end
        end

        // set known map: seg s -> block s (write ~s)
        for (int s = 0; s < 16; s++) io_write(16'(s << 12) | 16'h00DF, 8'(~s));
        // R3: neighbouring ports change nothing
        io_write(16'h30DC, 8'h00);
        io_write(16'h30E0, 8'h00);
        io_write(16'h309E, 8'h00);
        io_write(16'h305E, 8'h00);
        check("R3", {28'h0, seg_m[3]}, 32'h3);
        for (int s = 0; s < 16; s++) begin
            probe("R3", 16'(s << 12) | 16'h0456, 1'b1, 1'b1);
            probe("R7", 16'(s << 12) | 16'h0001, 1'b0, 1'b1);
            probe("R8", 16'(s << 12) | 16'h0800, 1'b1, 1'b0);
        end

        // R6: disabling takes one cycle; R5 writes forced to ROM get no strobe
        @(negedge clk);
        map_en = 1'b0;
        cpu_addr = 16'h4000;
        #1;
        check("R6", {12'h0, phys_addr}, {12'h0, 20'h44000});
        @(negedge clk);
        en_m = 1'b0;
        probe("R10", 16'h4000, 1'b0, 1'b1);
        probe("R11", 16'hC123, 1'b1, 1'b0);

        set_en(1'b1);
        probe("R11", 16'hD123, 1'b1, 1'b1);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule